// File: doc/BRIEF.md
# Sensor Result Register Target on a Two-Wire Bus

This block is a target on a two-wire serial bus (I2C). A bus master reaches a small byte-addressed register space through it. The space holds two control bytes that the master can read and write, a fixed identity byte, and the latest averaged results of two 16-bit sensor channels. The sampling core delivers those results on parallel inputs. The control bytes are driven straight out to the sampling core, which uses them to select channels, set the averaging depth and set the timer period.

The target runs on the system clock and oversamples the bus. Both lines pass through synchronizer flops. START and STOP are found as data-line edges while the clock line is high. The target pulls the data line low only through an open-drain enable. After the device address, the first byte a master writes is the register pointer. Every byte after that lands at the pointer, and the pointer then steps forward. Reads stream out from the pointer with the same auto-increment. When the high byte of a channel result is read, the low byte is captured at the same moment, so the two bytes of one result always come from the same sample.

Top module: `sensor_i2c_target`

## Requirements
- R1: The target acknowledges only the 7-bit address 0x08. The address byte is 0x10 for a write and 0x11 for a read. For any other address it never pulls the data line low and changes no register.
- R2: START (data line falls while the clock line is high) always begins a new address phase, including a repeated START in the middle of a transfer. STOP (data line rises while the clock line is high) ends the transfer and releases the data line.
- R3: Register 0x02 always reads 0xBC.
- R4: Registers 0x00 and 0x01 reset to 0x00. Master writes can change them, and their values appear on ctrl0 and ctrl1 respectively.
- R5: Data bytes written to pointer values 0x02 and above are acknowledged but change no register.
- R6: Channel 0 reads as bits 15..8 at 0x03 and bits 7..0 at 0x04. Channel 1 reads the same way at 0x05 and 0x06. Every pointer above 0x06 reads 0x00.
- R7: Reading a channel high byte (0x03 or 0x05) captures that channel's low byte. The next address (0x04 or 0x06) returns the captured value, even if the channel input changed in between.
- R8: After the address, the first byte written in a transfer loads the pointer. Later bytes are written at the pointer, which then increments. Each byte sent on a read increments the pointer. The pointer keeps its value across STOP.
- R9: The data line enable only turns on while the clock line is low. A master NACK after a read byte ends the read with the data line released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, the data line is pulled low (open drain) |
| ch0_data | input | 16 | Averaged result of channel 0 |
| ch1_data | input | 16 | Averaged result of channel 1 |
| ctrl0 | output | 8 | Control byte at register 0x00 |
| ctrl1 | output | 8 | Control byte at register 0x01 |

## Verification
The master model covers several access patterns. A plain write sets the pointer and then the control bytes. A write of the pointer followed by a repeated START and a read sweeps the whole map and one address past its end, which separates correct byte order and decoding from an off-by-one pointer. A read that starts after a separate pointer-only transfer shows whether the pointer survives STOP. A channel value that changes between its two byte reads shows whether the low byte was captured, and a design that reads the live input fails there. Writes into the read-only region, a foreign address and a pointer reload after an aborted transfer show that ignored traffic leaves the control outputs unchanged.

// File: rtl/sensor_i2c_pkg.sv
package sensor_i2c_pkg;

    localparam logic [6:0] DEF_DEV_ADDR = 7'h08;
    localparam logic [7:0] DEF_ID_BYTE  = 8'hBC;
    localparam int         NUM_CH       = 2;
    localparam int         CH_W         = 16;
    localparam logic [7:0] REG_CTRL0    = 8'h00;
    localparam logic [7:0] REG_CTRL1    = 8'h01;
    localparam logic [7:0] REG_ID       = 8'h02;
    localparam logic [7:0] REG_CH_BASE  = 8'h03;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
    } bus_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } line_ev_t;

    typedef struct packed {
        logic       stb;
        logic       is_ptr;
        logic [7:0] data;
    } wr_req_t;

    function automatic logic [7:0] ch_hi_addr(int idx);
        return 8'(int'(REG_CH_BASE) + 2 * idx);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import sensor_i2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    // bit 0 takes the raw pin, bit STAGES-1 is the settled level, bit STAGES is one cycle older
    logic [STAGES:0] scl_sh;
    logic [STAGES:0] sda_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[STAGES-1:0], scl_i};
            sda_sh <= {sda_sh[STAGES-1:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_sh[STAGES-1];
    assign scl_old = scl_sh[STAGES];
    assign sda_now = sda_sh[STAGES-1];
    assign sda_old = sda_sh[STAGES];

    always_comb begin
        ev.scl   = scl_now;
        ev.sda   = sda_now;
        ev.rise  = scl_now & ~scl_old;
        ev.fall  = ~scl_now & scl_old;
        ev.start = scl_now & scl_old & sda_old & ~sda_now;
        ev.stop  = scl_now & scl_old & ~sda_old & sda_now;
    end

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import sensor_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = DEF_DEV_ADDR
) (
    input  logic       clk,
    input  logic       rst,
    input  line_ev_t   ev,
    input  logic [7:0] rd_byte,
    output logic       sda_oe,
    output logic       fetch,
    output wr_req_t    wr
);
    bus_state_e state;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic       rw;
    logic       first;
    logic       nack;

    assign fetch   = ev.fall && ((state == ST_ADDR_ACK && rw) || (state == ST_RACK && !nack));
    assign wr.stb    = ev.fall && state == ST_WDATA && cnt == 4'd8;
    assign wr.is_ptr = first;
    assign wr.data   = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            rw     <= 1'b0;
            first  <= 1'b0;
            nack   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WDATA: begin
                    if (ev.rise) begin
                        shreg <= {shreg[6:0], ev.sda};
                        cnt   <= cnt + 4'd1;
                    end else if (ev.fall && cnt == 4'd8) begin
                        if (state == ST_WDATA) begin
                            state  <= ST_WACK;
                            sda_oe <= 1'b1;
                            first  <= 1'b0;
                        end else if (shreg[7:1] == DEV_ADDR) begin
                            state  <= ST_ADDR_ACK;
                            sda_oe <= 1'b1;
                            rw     <= shreg[0];
                            first  <= 1'b1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK, ST_WACK: begin
                    if (ev.fall) begin
                        cnt <= '0;
                        if (state == ST_ADDR_ACK && rw) begin
                            state  <= ST_RDATA;
                            shreg  <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                        end else begin
                            state  <= ST_WDATA;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (ev.rise) begin
                        cnt <= cnt + 4'd1;
                    end else if (ev.fall) begin
                        if (cnt == 4'd8) begin
                            state  <= ST_RACK;
                            sda_oe <= 1'b0;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.rise) begin
                        nack <= ev.sda;
                    end else if (ev.fall) begin
                        cnt <= '0;
                        if (nack) begin
                            state <= ST_IDLE;
                        end else begin
                            state  <= ST_RDATA;
                            shreg  <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R9: pull-down only begins while the settled clock line is low
    p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl);

    // R1: the idle target never holds the line
    p_idle_release_r1: assert property (@(posedge clk) disable iff (rst)
        state == ST_IDLE |-> !sda_oe);

    // R1: a foreign address drops back to idle
    p_foreign_addr_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR && ev.fall && cnt == 4'd8 && shreg[7:1] != DEV_ADDR)
        |=> state == ST_IDLE);

    // R2: START re-enters the address phase
    p_start_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (ev.start && !ev.stop) |=> state == ST_ADDR && !sda_oe);

endmodule

// File: rtl/sensor_regfile.sv
module sensor_regfile
    import sensor_i2c_pkg::*;
#(
    parameter logic [7:0] ID_BYTE = DEF_ID_BYTE
) (
    input  logic                         clk,
    input  logic                         rst,
    input  wr_req_t                      wr,
    input  logic                         fetch,
    input  logic [NUM_CH-1:0][CH_W-1:0]  ch,
    output logic [7:0]                   rd_byte,
    output logic [7:0]                   ctrl0,
    output logic [7:0]                   ctrl1
);
    localparam int LO_W = CH_W - 8;

    logic [7:0]                  ptr;
    logic [NUM_CH-1:0][LO_W-1:0] hold;

    always_comb begin
        rd_byte = 8'h00;
        if (ptr == REG_CTRL0) rd_byte = ctrl0;
        if (ptr == REG_CTRL1) rd_byte = ctrl1;
        if (ptr == REG_ID)    rd_byte = ID_BYTE;
        for (int k = 0; k < NUM_CH; k++) begin
            if (ptr == ch_hi_addr(k))         rd_byte = ch[k][CH_W-1:LO_W];
            if (ptr == ch_hi_addr(k) + 8'd1)  rd_byte = hold[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            ctrl0 <= '0;
            ctrl1 <= '0;
            hold  <= '0;
        end else begin
            if (wr.stb) begin
                if (wr.is_ptr) begin
                    ptr <= wr.data;
                end else begin
                    if (ptr == REG_CTRL0) ctrl0 <= wr.data;
                    if (ptr == REG_CTRL1) ctrl1 <= wr.data;
                    ptr <= ptr + 8'd1;
                end
            end
            if (fetch) begin
                ptr <= ptr + 8'd1;
                for (int k = 0; k < NUM_CH; k++)
                    if (ptr == ch_hi_addr(k)) hold[k] <= ch[k][LO_W-1:0];
            end
        end
    end

    // R4: control bytes move only on a data write
    p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !wr.stb |=> $stable(ctrl0) && $stable(ctrl1));

    // R5: writes into the read-only region leave control bytes alone
    p_ro_guard_r5: assert property (@(posedge clk) disable iff (rst)
        (wr.stb && !wr.is_ptr && ptr > REG_CTRL1) |=> $stable(ctrl0) && $stable(ctrl1));

    // R8: each byte sent on a read steps the pointer by one
    p_ptr_step_r8: assert property (@(posedge clk) disable iff (rst)
        fetch |=> ptr == $past(ptr) + 8'd1);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_latch_chk
        // R7: low byte captured with the high-byte read
        p_low_latch_r7: assert property (@(posedge clk) disable iff (rst)
            (fetch && ptr == ch_hi_addr(g)) |=> hold[g] == $past(ch[g][LO_W-1:0]));
    end

endmodule

// File: rtl/sensor_i2c_target.sv
module sensor_i2c_target
    import sensor_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = DEF_DEV_ADDR,
    parameter logic [7:0] ID_BYTE     = DEF_ID_BYTE,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [15:0] ch0_data,
    input  logic [15:0] ch1_data,
    output logic [7:0]  ctrl0,
    output logic [7:0]  ctrl1
);
    line_ev_t                   ev;
    wr_req_t                    wr;
    logic                       fetch;
    logic [7:0]                 rd_byte;
    logic [NUM_CH-1:0][CH_W-1:0] ch_bus;

    assign ch_bus = {ch1_data, ch0_data};

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_byte (rd_byte),
        .sda_oe  (sda_oe),
        .fetch   (fetch),
        .wr      (wr)
    );

    sensor_regfile #(.ID_BYTE(ID_BYTE)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .fetch   (fetch),
        .ch      (ch_bus),
        .rd_byte (rd_byte),
        .ctrl0   (ctrl0),
        .ctrl1   (ctrl1)
    );

endmodule

// File: tb/tb_sensor_i2c_target.sv
module tb_sensor_i2c_target;

    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        scl_m, sda_m;
    logic        sda_oe;
    logic        sda_line;
    logic [15:0] ch0, ch1;
    logic [7:0]  ctrl0, ctrl1;

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    sensor_i2c_target dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .ch0_data (ch0),
        .ch1_data (ch1),
        .ctrl0    (ctrl0),
        .ctrl1    (ctrl1)
    );

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    event       rx_ev;
    logic [7:0] rx_byte;
    logic       swap_en = 1'b0;
    logic [15:0] swap_val;

    int  oe_cycles = 0;
    int  oe_viol = 0;
    logic oe_prev = 1'b0;

    always @(posedge clk) begin
        if (sda_oe) oe_cycles <= oe_cycles + 1;
        if (!rst && sda_oe && !oe_prev && scl_m) oe_viol <= oe_viol + 1;
        oe_prev <= sda_oe;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic expect_rd(input logic [7:0] v, input string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compares each received byte against the oldest expected item
    initial begin
        forever begin
            @(rx_ev);
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard-empty", rx_byte, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rx_byte == e.val, e.tag, rx_byte, e.val);
            end
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic rd_byte(input logic ack);
        logic [7:0] v;
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        if (swap_en) begin
            ch0 = swap_val;
            swap_en = 1'b0;
        end
        rx_byte = v;
        -> rx_ev;
        put_bit(~ack);
    endtask

    logic ak;
    int   snap;

    initial begin
        rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
        ch0 = 16'hA15C; ch1 = 16'h07E3;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        wq();

        // R4 reset state
        check(ctrl0 == 8'h00, "R4 ctrl0 reset", ctrl0, 8'h00);
        check(ctrl1 == 8'h00, "R4 ctrl1 reset", ctrl1, 8'h00);
        check(sda_oe == 1'b0, "R9 released after reset", sda_oe, 0);

        // R1/R8: pointer then two control bytes
        bus_start();
        wr_byte(8'h10, ak); check(ak, "R1 address 0x08 write acked", ak, 1);
        wr_byte(8'h00, ak);
        wr_byte(8'h2D, ak);
        wr_byte(8'h7F, ak);
        bus_stop();
        check(ctrl0 == 8'h2D, "R4 R8 ctrl0 written", ctrl0, 8'h2D);
        check(ctrl1 == 8'h7F, "R4 R8 ctrl1 at next pointer", ctrl1, 8'h7F);

        // R2 repeated START, full sweep R3 R6 R8
        bus_start();
        wr_byte(8'h10, ak);
        wr_byte(8'h00, ak);
        bus_start();
        wr_byte(8'h11, ak); check(ak, "R2 read after repeated START acked", ak, 1);
        expect_rd(8'h2D, "R8 read ctrl0");
        expect_rd(8'h7F, "R8 read ctrl1");
        expect_rd(8'hBC, "R3 identity byte");
        expect_rd(8'hA1, "R6 ch0 high");
        expect_rd(8'h5C, "R6 ch0 low");
        expect_rd(8'h07, "R6 ch1 high");
        expect_rd(8'hE3, "R6 ch1 low");
        expect_rd(8'h00, "R6 beyond map");
        for (int i = 0; i < 7; i++) rd_byte(1'b1);
        rd_byte(1'b0);
        wq();
        check(sda_oe == 1'b0, "R9 released after NACK", sda_oe, 0);
        bus_stop();

        // R8 pointer kept across STOP
        bus_start();
        wr_byte(8'h10, ak);
        wr_byte(8'h05, ak);
        bus_stop();
        bus_start();
        wr_byte(8'h11, ak);
        expect_rd(8'h07, "R8 pointer persists over STOP");
        rd_byte(1'b0);
        bus_stop();

        // R7 low byte captured with high byte
        bus_start();
        wr_byte(8'h10, ak);
        wr_byte(8'h03, ak);
        bus_start();
        wr_byte(8'h11, ak);
        swap_val = 16'hBEEF; swap_en = 1'b1;
        expect_rd(8'hA1, "R7 high byte before change");
        expect_rd(8'h5C, "R7 low byte from same sample");
        rd_byte(1'b1);
        rd_byte(1'b0);
        bus_stop();
        bus_start();
        wr_byte(8'h10, ak);
        wr_byte(8'h03, ak);
        bus_start();
        wr_byte(8'h11, ak);
        expect_rd(8'hBE, "R7 new high byte");
        expect_rd(8'hEF, "R7 new low byte");
        rd_byte(1'b1);
        rd_byte(1'b0);
        bus_stop();

        // R5 writes into read-only region
        bus_start();
        wr_byte(8'h10, ak);
        wr_byte(8'h02, ak);
        wr_byte(8'h55, ak); check(ak, "R5 write to identity acked", ak, 1);
        wr_byte(8'h66, ak);
        wr_byte(8'h77, ak);
        wr_byte(8'h88, ak); check(ak, "R5 write to ch1 high acked", ak, 1);
        bus_stop();
        check(ctrl0 == 8'h2D, "R5 ctrl0 untouched", ctrl0, 8'h2D);
        check(ctrl1 == 8'h7F, "R5 ctrl1 untouched", ctrl1, 8'h7F);
        bus_start();
        wr_byte(8'h10, ak);
        wr_byte(8'h02, ak);
        bus_start();
        wr_byte(8'h11, ak);
        expect_rd(8'hBC, "R5 identity not overwritten");
        expect_rd(8'hBE, "R5 ch0 high not overwritten");
        rd_byte(1'b1);
        rd_byte(1'b0);
        bus_stop();

        // R1 foreign address
        snap = oe_cycles;
        bus_start();
        wr_byte(8'h12, ak); check(!ak, "R1 address 0x09 not acked", ak, 0);
        wr_byte(8'h00, ak);
        wr_byte(8'h11, ak);
        bus_stop();
        check(oe_cycles == snap, "R1 line never driven for foreign address", oe_cycles - snap, 0);
        check(ctrl0 == 8'h2D, "R1 ctrl0 unchanged by foreign write", ctrl0, 8'h2D);

        // R2 R8 aborted transfer, new transfer reloads pointer
        bus_start();
        wr_byte(8'h10, ak);
        wr_byte(8'h00, ak);
        bus_stop();
        bus_start();
        wr_byte(8'h10, ak);
        wr_byte(8'h01, ak);
        wr_byte(8'h3C, ak);
        bus_stop();
        check(ctrl0 == 8'h2D, "R8 first byte is pointer, ctrl0 kept", ctrl0, 8'h2D);
        check(ctrl1 == 8'h3C, "R2 R8 ctrl1 via reloaded pointer", ctrl1, 8'h3C);

        wq();
        check(oe_viol == 0, "R9 enable rose while clock high", oe_viol, 0);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule